// File: doc/BRIEF.md
# Channel Activity Counters with Snapshot Freeze

The block measures how a radio MAC spends its time. Four 32-bit counters run on the MAC clock. The first counts every clock. The second counts clocks where the receiver reports the channel as busy. The third counts clocks spent receiving a frame. The fourth counts clocks spent transmitting a frame. The activity indications arrive as level strobes from logic outside this block.

Software reaches the counters through a small register port. A control bit stops all four counters on the same edge, so software can read them as one consistent snapshot. Writing zero to a counter's address clears it. Writing zero to the control bit starts counting again.

A helper output reports idle listen time in milliseconds. It is derived from the live counter values and from a configured clock rate in MHz. Software typically samples it while the counters are frozen.

Top module: `chan_activity_counters`

## Requirements
- R1: While not frozen, the total counter (address 1) increments on every clock. The busy counter (address 2), receive counter (address 3) and transmit counter (address 4) each increment on clocks where busy_i, rx_frame_i or tx_frame_i respectively is high.
- R2: While frozen, no counter changes because of its activity input. The activity inputs have no effect on any value read back.
- R3: Address 0 is the control register, and its bit 0 is the freeze bit. A write with bit 0 set freezes from the next clock on. A write with bit 0 clear unfreezes. Reading address 0 returns the freeze bit in bit 0 and zeros in all other bits.
- R4: A write to a counter address loads wdata_i into that counter, so writing zero clears it. The write takes effect whether or not the counters are frozen, and it wins over an increment in the same cycle.
- R5: Each counter wraps from 2^32-1 to 0.
- R6: A read request raises rvalid_o for exactly one cycle, on the next clock. rdata_o then carries the value the addressed register held at the requesting edge. Addresses 5 to 7 read as zero.
- R7: listen_ms_o equals floor((total − receive − transmit) / (clk_mhz_i × 1000)), computed from the counter values at the previous edge. It is zero when clk_mhz_i is zero or when receive + transmit exceeds total.
- R8: Writes to addresses 5 to 7 change neither the counters nor the freeze bit.
- R9: After reset every counter is zero, the counters are unfrozen, rvalid_o is low and listen_ms_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | MAC clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Receiver sees the channel busy this cycle |
| rx_frame_i | input | 1 | A frame is being received this cycle |
| tx_frame_i | input | 1 | A frame is being transmitted this cycle |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| clk_mhz_i | input | 8 | Clock rate in MHz used for the listen time |
| listen_ms_o | output | 32 | Idle listen time in milliseconds |

## Verification
Assertions check several rules on every cycle: each counter holds while frozen, increments by exactly one when active, and takes the written value on a load. They also check the freeze bit's set and hold rules, the one-cycle read latency, and the zero result for a zero clock rate. The bench scenarios are needed for the rest. They show that read data matches a snapshot after mixed activity patterns, that wrapping happens at 2^32, that writes to unmapped addresses are harmless, and that the listen arithmetic and its underflow guard give the right values.

// File: rtl/chan_act_pkg.sv
package chan_act_pkg;
  localparam int unsigned NUM_CNT = 4;
  localparam int unsigned ADDR_W  = 3;

  // counter slots; slot i is mapped at register address i+1
  localparam int unsigned SLOT_CYC  = 0;
  localparam int unsigned SLOT_BUSY = 1;
  localparam int unsigned SLOT_RXF  = 2;
  localparam int unsigned SLOT_TXF  = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam int unsigned       MS_PER_MHZ = 1000;
endpackage

// File: rtl/chan_act_counter.sv
module chan_act_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frz_i,
  input  logic             act_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (ld_i)              cnt_q <= ld_val_i;
    else if (!frz_i && act_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_frozen_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_i && !ld_i) |=> $stable(cnt_o));
  p_incr_one_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frz_i && act_i && !ld_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
  p_idle_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_i && !ld_i) |=> $stable(cnt_o));
  p_load_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (cnt_o == $past(ld_val_i)));
endmodule

// File: rtl/chan_act_regs.sv
module chan_act_regs
  import chan_act_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic                          rd_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [CNT_W-1:0]              wdata_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_i,
  output logic                          frz_o,
  output logic [NUM_CNT-1:0]            ld_o,
  output logic [CNT_W-1:0]              rdata_o,
  output logic                          rvalid_o
);
  logic             frz_q;
  logic             ctrl_wr;
  logic [CNT_W-1:0] rd_mux;
  logic [CNT_W-1:0] rdata_q;
  logic             rvalid_q;

  assign ctrl_wr = wr_en_i && (addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      frz_q <= 1'b0;
    else if (ctrl_wr) frz_q <= wdata_i[0];
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_ld
    assign ld_o[g] = wr_en_i && (addr_i == ADDR_W'(g + 1));
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_CTRL) rd_mux[0] = frz_q;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (addr_i == ADDR_W'(i + 1)) rd_mux = cnt_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  assign frz_o    = frz_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  p_frz_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_CTRL) |=> (frz_o == $past(wdata_i[0])));
  p_frz_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_CTRL) |=> $stable(frz_o));
  p_rd_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
  p_rd_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o);
  p_unmapped_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i > ADDR_W'(NUM_CNT)) |=> (rdata_o == '0));
endmodule

// File: rtl/chan_act_listen.sv
module chan_act_listen
  import chan_act_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned MHZ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cyc_i,
  input  logic [CNT_W-1:0] rxf_i,
  input  logic [CNT_W-1:0] txf_i,
  input  logic [MHZ_W-1:0] mhz_i,
  output logic [CNT_W-1:0] listen_o
);
  localparam int unsigned DEN_W = MHZ_W + 10;

  logic [CNT_W:0]   used;
  logic             fits;
  logic [CNT_W-1:0] idle;
  logic [DEN_W-1:0] den;
  logic [CNT_W-1:0] den_ext;
  logic [CNT_W-1:0] quo;
  logic [CNT_W-1:0] listen_q;

  assign used    = {1'b0, rxf_i} + {1'b0, txf_i};
  assign fits    = used <= {1'b0, cyc_i};
  assign idle    = cyc_i - used[CNT_W-1:0];
  assign den     = DEN_W'(mhz_i) * DEN_W'(MS_PER_MHZ);
  assign den_ext = {{(CNT_W-DEN_W){1'b0}}, den};

  always_comb begin
    quo = '0;
    if (fits && mhz_i != '0) quo = idle / den_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) listen_q <= '0;
    else         listen_q <= quo;
  end

  assign listen_o = listen_q;

  p_zero_rate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mhz_i == '0) |=> (listen_o == '0));
  p_bounded_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (listen_o <= $past(cyc_i)));
endmodule

// File: rtl/chan_activity_counters.sv
module chan_activity_counters
  import chan_act_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned MHZ_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              rx_frame_i,
  input  logic              tx_frame_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              rvalid_o,
  input  logic [MHZ_W-1:0]  clk_mhz_i,
  output logic [CNT_W-1:0]  listen_ms_o
);
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [NUM_CNT-1:0]            act;
  logic [NUM_CNT-1:0]            ld;
  logic                          frz;

  always_comb begin
    act            = '0;
    act[SLOT_CYC]  = 1'b1;
    act[SLOT_BUSY] = busy_i;
    act[SLOT_RXF]  = rx_frame_i;
    act[SLOT_TXF]  = tx_frame_i;
  end

  chan_act_regs #(.CNT_W(CNT_W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .cnt_i    (cnt),
    .frz_o    (frz),
    .ld_o     (ld),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    chan_act_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .frz_i    (frz),
      .act_i    (act[g]),
      .ld_i     (ld[g]),
      .ld_val_i (wdata_i),
      .cnt_o    (cnt[g])
    );
  end

  chan_act_listen #(.CNT_W(CNT_W), .MHZ_W(MHZ_W)) i_listen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cyc_i    (cnt[SLOT_CYC]),
    .rxf_i    (cnt[SLOT_RXF]),
    .txf_i    (cnt[SLOT_TXF]),
    .mhz_i    (clk_mhz_i),
    .listen_o (listen_ms_o)
  );

  // all counters stop together: total counter never moves while frozen
  p_joint_freeze_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz && !wr_en_i) |=> $stable(cnt));
  p_cyc_runs_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frz && !ld[SLOT_CYC]) |=> (cnt[SLOT_CYC] != $past(cnt[SLOT_CYC])));
endmodule

// File: tb/test_chan_activity_counters.sv
module test_chan_activity_counters;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busy = 1'b0, rxf = 1'b0, txf = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [7:0]  mhz = '0;
  logic [31:0] listen;

  int checks = 0;
  int fails  = 0;

  typedef struct { logic [31:0] val; string req; } exp_t;
  exp_t exp_q[$];

  logic [31:0] m_cnt [4];
  logic        m_frz;
  int          act_mode = 0;
  int          phase = 0;

  always #5 clk = ~clk;

  chan_activity_counters i_chan_activity_counters (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .rx_frame_i(rxf),
    .tx_frame_i(txf), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .clk_mhz_i(mhz), .listen_ms_o(listen)
  );

  // reference model from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_cnt[i] <= '0;
      m_frz <= 1'b0;
    end else begin
      logic [3:0] a;
      a = {txf, rxf, busy, 1'b1};
      if (wr_en && addr == 3'd0) m_frz <= wdata[0];
      for (int i = 0; i < 4; i++) begin
        if (wr_en && addr == 3'(i + 1))  m_cnt[i] <= wdata;
        else if (!m_frz && a[i])         m_cnt[i] <= m_cnt[i] + 32'd1;
      end
    end
  end

  // activity stimulus
  always @(negedge clk) begin
    phase <= phase + 1;
    if (act_mode == 0) begin
      busy <= 1'b0; rxf <= 1'b0; txf <= 1'b0;
    end else if (act_mode == 1) begin
      busy <= phase[0];
      rxf  <= (phase % 3) == 0;
      txf  <= phase[3];
    end else begin
      busy <= 1'b1;
      rxf  <= (phase % 4) == 0;
      txf  <= (phase % 8) == 1;
    end
  end

  task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare read data against queued expectations
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6 actual=unexpected rvalid expected=no read");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check32(rdata, e.val, e.req);
      end
    end
  end

  // driver tasks: called at a negedge, return at the next negedge
  task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] a, input string req);
    exp_t e;
    if (a == 3'd0)      e.val = {31'b0, m_frz};
    else if (a <= 3'd4) e.val = m_cnt[a - 1];
    else                e.val = '0;
    e.req = req;
    exp_q.push_back(e);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_all(input string req);
    for (int i = 1; i <= 4; i++) do_rd(3'(i), req);
  endtask

  function automatic logic [31:0] m_listen();
    longint c, r, t;
    c = m_cnt[0]; r = m_cnt[2]; t = m_cnt[3];
    if (mhz == 0 || r + t > c) return '0;
    return 32'((c - r - t) / (longint'(mhz) * 1000));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check32({31'b0, rvalid}, 32'd0, "R9 rvalid in reset");
    check32(listen, 32'd0, "R9 listen in reset");
    rst_n = 1'b1;
    do_rd(3'd1, "R9 total after reset");
    do_rd(3'd2, "R9 busy after reset");
    do_rd(3'd0, "R9 ctrl after reset");
    do_rd(3'd4, "R9 tx after reset");

    // R1: two activity patterns, live reads
    act_mode = 1;
    repeat (37) @(negedge clk);
    rd_all("R1 pattern A");
    act_mode = 2;
    repeat (21) @(negedge clk);
    rd_all("R1 pattern B");

    // R2/R3: freeze, activity must not matter
    do_wr(3'd0, 32'h0000_0001);
    do_rd(3'd0, "R3 ctrl reads frozen");
    act_mode = 1;
    repeat (15) @(negedge clk);
    rd_all("R2 frozen snapshot");
    repeat (9) @(negedge clk);
    rd_all("R2 frozen still");

    // R8: unmapped writes, R6: unmapped reads
    do_wr(3'd5, 32'hFFFF_FFFF);
    do_wr(3'd6, 32'h0000_0000);
    do_wr(3'd7, 32'h1234_5678);
    do_rd(3'd0, "R8 ctrl unchanged");
    rd_all("R8 counters unchanged");
    do_rd(3'd5, "R6 unmapped 5");
    do_rd(3'd7, "R6 unmapped 7");

    // R4: clears while frozen
    for (int i = 1; i <= 4; i++) do_wr(3'(i), 32'd0);
    rd_all("R4 cleared while frozen");

    // R3: unfreeze with zero write
    do_wr(3'd0, 32'h0000_0000);
    do_rd(3'd0, "R3 ctrl unfrozen");
    repeat (5) @(negedge clk);
    rd_all("R3 counting resumed");

    // R4: load wins over increment while busy is high
    act_mode = 2;
    do_wr(3'd2, 32'h0000_0100);
    do_rd(3'd2, "R4 load over increment");

    // R5: wrap
    do_wr(3'd0, 32'h1);
    do_wr(3'd1, 32'hFFFF_FFFE);
    do_wr(3'd2, 32'hFFFF_FFFF);
    do_wr(3'd0, 32'h0);
    repeat (4) @(negedge clk);
    do_wr(3'd0, 32'h1);
    do_rd(3'd1, "R5 total wrapped");
    do_rd(3'd2, "R5 busy wrapped");
    check32({31'b0, m_cnt[0] < 32'd16}, 32'd1, "R5 total small after wrap");

    // R7: listen time from real activity
    for (int i = 1; i <= 4; i++) do_wr(3'(i), 32'd0);
    mhz = 8'd1;
    do_wr(3'd0, 32'h0);
    repeat (6000) @(negedge clk);
    do_wr(3'd0, 32'h1);
    repeat (3) @(negedge clk);
    check32(listen, m_listen(), "R7 listen from activity");
    mhz = 8'd0;
    repeat (2) @(negedge clk);
    check32(listen, 32'd0, "R7 zero clock rate");
    mhz = 8'd1;
    do_wr(3'd1, 32'd5);
    do_wr(3'd3, 32'd10);
    repeat (2) @(negedge clk);
    check32(listen, 32'd0, "R7 underflow guard");
    do_wr(3'd1, 32'd2_000_000);
    do_wr(3'd3, 32'd0);
    do_wr(3'd4, 32'd0);
    mhz = 8'd2;
    repeat (2) @(negedge clk);
    check32(listen, 32'd1000, "R7 exact quotient");
    do_wr(3'd3, 32'd2_500);
    do_wr(3'd4, 32'd1);
    repeat (2) @(negedge clk);
    check32(listen, 32'd998, "R7 floor");

    repeat (3) @(negedge clk);
    check32(32'(exp_q.size()), 32'd0, "R6 all reads answered");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule